// File: doc/BRIEF.md
# Two-Channel Instruction and Data Breakpoint Unit

This block is a debug breakpoint unit with two independent watch channels, A and B. It observes a trace port from an in-order processor. Each trace sample is either an instruction fetch or a data access. A fetch sample carries the instruction address. It also says whether the instruction will really execute, whether it is a delayed branch, and whether that branch is taken. A data sample carries the address, direction, operand size and data. When a channel's condition is met, the block sets that channel's status flag and raises a break request towards the processor. It also records a stop address: the instruction before which the processor must stop, or for data breaks the accessed address.

A fetch-cycle channel can stop the processor either before or after the matched instruction executes. Instructions that are fetched and then dropped never count. The stop point is moved around delayed branches: a pre-execution break on a delay slot stops before the owning branch, and a post-execution break on a delayed branch or its slot is held back until the first instruction at the branch target. Only channel B can also compare data.

Software sets the unit up through a word-addressed write port with a combinational read port.

Register indices (reg_addr):
- 0: channel A address
- 1: channel A mask
- 2: channel A control
- 4: channel B address
- 5: channel B mask
- 6: channel B control
- 7: channel B data value
- 8: channel B data mask
- 9: status (bit 0 channel A, bit 1 channel B)
- 10: stop address (read only)

Control word bits:
- bit 0: enable
- bit 1: cycle kind (0 fetch, 1 data)
- bit 2: match reads
- bit 3: match writes
- bits 5:4: size filter (0 any, 1 byte, 2 word, 3 long)
- bit 6: post-execution
- bit 7: data compare, honoured on channel B only

Top module: `brk_unit`

## Requirements
- R1: After reset, brk_req is 0, brk_stop is 0, and every register reads 0.
- R2: Each writable register reads back the value written at its index. Writing the status register (index 9) clears each flag whose write-data bit is 0 and leaves a flag whose bit is 1 unchanged.
- R3: An enabled fetch channel in pre-execution mode (control bit 6 = 0) whose address matches an executed fetch (tr_exec=1) sets its flag on the next clock edge. The stop address becomes that fetch's address.
- R4: A fetch channel whose address register has bit 0 set to 1 never raises a break.
- R5: A fetch sample with tr_exec=0 never raises a break. It does not count as a delayed branch, a delay slot, or the instruction that completes a pending post-execution break.
- R6: A post-execution match on an ordinary instruction raises the break on the next executed fetch. The stop address is that next fetch's address.
- R7: A pre-execution match on the delay slot of a taken delayed branch (tr_dbranch=1, tr_taken=1) raises the break with the branch's address as the stop address.
- R8: A post-execution match on a taken delayed branch, or on its delay slot, raises the break at the first executed fetch after the slot. The stop address is that target address.
- R9: After a delayed branch with tr_taken=0, the next instruction is ordinary. A pre-execution match on it stops at its own address, and a post-execution match on the branch fires at that instruction.
- R10: An address mask bit set to 1 removes that address bit from the comparison.
- R11: A data channel (control bit 1 = 1) matches only when the direction is allowed by bits 3:2 and the size is allowed by bits 5:4. The trace encodes size as tr_size 1 = byte, 2 = word, 3 = long. Address bit 0 is ignored for word accesses, and bits 1:0 are ignored for long accesses.
- R12: On channel B, with bit 7 set for a data access, the low 8, 16 or all data bits (by size) must equal the data register except where the data mask has 1s. For fetch cycles the data value is ignored.
- R13: brk_req is 1 exactly while at least one status flag is set. A flag stays set until software clears it.
- R14: The stop address is captured only by a break raised while no flag is set. Later breaks leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational) |
| tr_valid | input | 1 | Trace sample present |
| tr_fetch | input | 1 | 1 instruction fetch, 0 data access |
| tr_exec | input | 1 | Fetched instruction will execute |
| tr_dbranch | input | 1 | Fetched instruction is a delayed branch |
| tr_taken | input | 1 | Delayed branch is taken |
| tr_write | input | 1 | Data access is a write |
| tr_size | input | 2 | Data access size code |
| tr_addr | input | W | Access or instruction address |
| tr_data | input | W | Access data |
| brk_req | output | 1 | Break request to the processor |
| brk_stop | output | W | Captured stop address |

## Verification
The bench targets the stop point around delayed branches. A design that ignores delay slots would stop on the slot instead of the branch, or would fire a post-execution break inside the slot rather than at the target. Not-taken branches are checked so that a unit which treats every delayed branch as taken would misplace the stop. Dropped fetches and fetch addresses with bit 0 set are driven to catch spurious breaks. A table of data-access cases covers size-dependent address bits, direction and size filters, masking and byte/word data lanes, where a missing lane or mask term would flip the result.

// File: rtl/brk_unit.sv
module brk_unit #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         reg_we,
  input  logic [3:0]   reg_addr,
  input  logic [W-1:0] reg_wdata,
  output logic [W-1:0] reg_rdata,
  input  logic         tr_valid,
  input  logic         tr_fetch,
  input  logic         tr_exec,
  input  logic         tr_dbranch,
  input  logic         tr_taken,
  input  logic         tr_write,
  input  logic [1:0]   tr_size,
  input  logic [W-1:0] tr_addr,
  input  logic [W-1:0] tr_data,
  output logic         brk_req,
  output logic [W-1:0] brk_stop
);

  localparam logic [3:0] IX_AADR = 4'd0, IX_AMSK = 4'd1, IX_ACTL = 4'd2;
  localparam logic [3:0] IX_BADR = 4'd4, IX_BMSK = 4'd5, IX_BCTL = 4'd6;
  localparam logic [3:0] IX_BDAT = 4'd7, IX_BDMK = 4'd8, IX_STAT = 4'd9, IX_STOP = 4'd10;
  localparam int CW = 8;

  logic [W-1:0]  adr_a, msk_a, adr_b, msk_b, dat_b, dmk_b, stop_q, last_pc;
  logic [CW-1:0] ctl_a, ctl_b;
  logic [1:0]    flag, arm, pre, raise;
  logic          in_slot, fetch_ok, data_ok_b;
  logic [W-1:0]  size_ign, lane, stop_a, stop_b;
  logic [1:0]    fh, dh;

  assign fetch_ok = tr_valid & tr_fetch & tr_exec;

  always_comb begin
    size_ign = '0;
    lane     = '1;
    case (tr_size)
      2'd1: lane = W'(8'hFF);
      2'd2: begin lane = W'(16'hFFFF); size_ign = W'(1); end
      2'd3: size_ign = W'(3);
      default: ;
    endcase
  end

  function automatic logic fetch_hit(input logic [CW-1:0] c, input logic [W-1:0] a, m);
    return c[0] & ~c[1] & fetch_ok & ~a[0] & (((tr_addr ^ a) & ~m) == '0);
  endfunction

  function automatic logic data_hit(input logic [CW-1:0] c, input logic [W-1:0] a, m);
    logic rw_ok, sz_ok;
    rw_ok = tr_write ? c[3] : c[2];
    sz_ok = (c[5:4] == 2'd0) | (c[5:4] == tr_size);
    return c[0] & c[1] & tr_valid & ~tr_fetch & rw_ok & sz_ok &
           (((tr_addr ^ a) & ~m & ~size_ign) == '0);
  endfunction

  assign data_ok_b = ~ctl_b[7] | (((tr_data ^ dat_b) & ~dmk_b & lane) == '0);

  assign fh[0] = fetch_hit(ctl_a, adr_a, msk_a);
  assign fh[1] = fetch_hit(ctl_b, adr_b, msk_b);
  assign dh[0] = data_hit(ctl_a, adr_a, msk_a);
  assign dh[1] = data_hit(ctl_b, adr_b, msk_b) & data_ok_b;
  assign pre   = fh & ~{ctl_b[6], ctl_a[6]};

  assign raise[0] = dh[0] | pre[0] | (arm[0] & fetch_ok & ~in_slot);
  assign raise[1] = dh[1] | pre[1] | (arm[1] & fetch_ok & ~in_slot);

  assign stop_a = (pre[0] & in_slot) ? last_pc : tr_addr;
  assign stop_b = (pre[1] & in_slot) ? last_pc : tr_addr;

  assign brk_req  = |flag;
  assign brk_stop = stop_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_a <= '0; msk_a <= '0; ctl_a <= '0;
      adr_b <= '0; msk_b <= '0; ctl_b <= '0;
      dat_b <= '0; dmk_b <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        IX_AADR: adr_a <= reg_wdata;
        IX_AMSK: msk_a <= reg_wdata;
        IX_ACTL: ctl_a <= reg_wdata[CW-1:0];
        IX_BADR: adr_b <= reg_wdata;
        IX_BMSK: msk_b <= reg_wdata;
        IX_BCTL: ctl_b <= reg_wdata[CW-1:0];
        IX_BDAT: dat_b <= reg_wdata;
        IX_BDMK: dmk_b <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag    <= '0;
      arm     <= '0;
      in_slot <= 1'b0;
      last_pc <= '0;
      stop_q  <= '0;
    end else begin
      flag <= ((reg_we && reg_addr == IX_STAT) ? (flag & reg_wdata[1:0]) : flag) | raise;
      if (!(|flag) && |raise)
        stop_q <= raise[0] ? stop_a : stop_b;
      if (fetch_ok) begin
        arm[0]  <= (fh[0] & ctl_a[6]) | (arm[0] & in_slot);
        arm[1]  <= (fh[1] & ctl_b[6]) | (arm[1] & in_slot);
        in_slot <= tr_dbranch & tr_taken & ~in_slot;
        last_pc <= tr_addr;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      IX_AADR: reg_rdata = adr_a;
      IX_AMSK: reg_rdata = msk_a;
      IX_ACTL: reg_rdata = W'(ctl_a);
      IX_BADR: reg_rdata = adr_b;
      IX_BMSK: reg_rdata = msk_b;
      IX_BCTL: reg_rdata = W'(ctl_b);
      IX_BDAT: reg_rdata = dat_b;
      IX_BDMK: reg_rdata = dmk_b;
      IX_STAT: reg_rdata = W'(flag);
      IX_STOP: reg_rdata = stop_q;
      default: reg_rdata = '0;
    endcase
  end

endmodule

module brk_unit_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         reg_we,
  input logic [3:0]   reg_addr,
  input logic         tr_valid,
  input logic         tr_fetch,
  input logic         tr_exec,
  input logic         brk_req,
  input logic [W-1:0] brk_stop,
  input logic [1:0]   flag,
  input logic [1:0]   arm,
  input logic         in_slot
);

  // R13
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag[0] && !(reg_we && reg_addr == 4'd9)) |=> flag[0]);

  // R14
  stop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    brk_req |=> $stable(brk_stop));

  // R5
  drop_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tr_valid && tr_fetch && !tr_exec && !brk_req && !reg_we) |=> !brk_req);

  // R6
  post_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm[0] && tr_valid && tr_fetch && tr_exec && !in_slot) |=> flag[0]);

  // R3
  raise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(brk_req) |-> $past(tr_valid));

endmodule

bind brk_unit brk_unit_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .tr_valid(tr_valid), .tr_fetch(tr_fetch), .tr_exec(tr_exec),
  .brk_req(brk_req), .brk_stop(brk_stop), .flag(flag), .arm(arm), .in_slot(in_slot)
);

// File: tb/brk_unit_tb.sv
module brk_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_we = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [W-1:0] reg_wdata = '0;
  logic [W-1:0] reg_rdata;
  logic         tr_valid = 1'b0, tr_fetch = 1'b0, tr_exec = 1'b0;
  logic         tr_dbranch = 1'b0, tr_taken = 1'b0, tr_write = 1'b0;
  logic [1:0]   tr_size = '0;
  logic [W-1:0] tr_addr = '0, tr_data = '0;
  logic         brk_req;
  logic [W-1:0] brk_stop;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  brk_unit #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tr_valid(tr_valid), .tr_fetch(tr_fetch), .tr_exec(tr_exec),
    .tr_dbranch(tr_dbranch), .tr_taken(tr_taken), .tr_write(tr_write),
    .tr_size(tr_size), .tr_addr(tr_addr), .tr_data(tr_data),
    .brk_req(brk_req), .brk_stop(brk_stop)
  );

  typedef struct packed {
    logic [7:0]  ctl;
    logic [31:0] adr;
    logic [31:0] msk;
    logic [31:0] dat;
    logic [31:0] dmk;
    logic        wr;
    logic [1:0]  sz;
    logic [31:0] ta;
    logic [31:0] td;
    logic        exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{8'h0F, 32'h1000, 32'h0,  32'h0,    32'h0,  1'b0, 2'd3, 32'h1000, 32'h0,        1'b1},
    '{8'h0F, 32'h1000, 32'h0,  32'h0,    32'h0,  1'b0, 2'd3, 32'h1004, 32'h0,        1'b0},
    '{8'h07, 32'h1000, 32'h0,  32'h0,    32'h0,  1'b1, 2'd3, 32'h1000, 32'h0,        1'b0},
    '{8'h2F, 32'h1000, 32'h0,  32'h0,    32'h0,  1'b0, 2'd3, 32'h1000, 32'h0,        1'b0},
    '{8'h2F, 32'h1000, 32'h0,  32'h0,    32'h0,  1'b0, 2'd2, 32'h1001, 32'h0,        1'b1},
    '{8'h1F, 32'h1000, 32'h0,  32'h0,    32'h0,  1'b0, 2'd1, 32'h1001, 32'h0,        1'b0},
    '{8'h3F, 32'h1000, 32'h0,  32'h0,    32'h0,  1'b1, 2'd3, 32'h1003, 32'h0,        1'b1},
    '{8'h0F, 32'h1000, 32'hF0, 32'h0,    32'h0,  1'b0, 2'd3, 32'h10A0, 32'h0,        1'b1},
    '{8'h8F, 32'h1000, 32'h0,  32'hAB,   32'h0,  1'b0, 2'd1, 32'h1000, 32'hFFFFFFAB, 1'b1},
    '{8'h8F, 32'h1000, 32'h0,  32'hAB,   32'h0,  1'b0, 2'd1, 32'h1000, 32'h000000AC, 1'b0},
    '{8'h8F, 32'h1000, 32'h0,  32'hAB,   32'h0F, 1'b0, 2'd1, 32'h1000, 32'h000000AC, 1'b1},
    '{8'h8F, 32'h1000, 32'h0,  32'h1234, 32'h0,  1'b0, 2'd2, 32'h1000, 32'h00001235, 1'b0}
  };

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [W-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [W-1:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic drive(input logic f, input logic ex, input logic db, input logic tk,
                       input logic w, input logic [1:0] sz,
                       input logic [W-1:0] a, input logic [W-1:0] d);
    @(negedge clk);
    tr_valid = 1'b1; tr_fetch = f; tr_exec = ex; tr_dbranch = db; tr_taken = tk;
    tr_write = w; tr_size = sz; tr_addr = a; tr_data = d;
    @(negedge clk);
    tr_valid = 1'b0; tr_exec = 1'b0; tr_dbranch = 1'b0; tr_taken = 1'b0;
  endtask

  task automatic fetch(input logic [W-1:0] a, input logic ex, input logic db, input logic tk);
    drive(1'b1, ex, db, tk, 1'b0, 2'd3, a, '0);
  endtask

  task automatic tidy();
    wr(4'd2, '0);
    wr(4'd6, '0);
    fetch(32'hF000, 1'b1, 1'b0, 1'b0);
    wr(4'd9, '0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [W-1:0] rv;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 brk_req", W'(brk_req), 0);
    chk("R1 brk_stop", brk_stop, 0);
    for (int i = 0; i < 11; i++) begin
      rd(4'(i), rv);
      chk("R1 register", rv, 0);
    end

    // R2 readback
    wr(4'd0, 32'h1234_5678); rd(4'd0, rv); chk("R2 A addr", rv, 32'h1234_5678);
    wr(4'd8, 32'h00FF_00F0); rd(4'd8, rv); chk("R2 B dmask", rv, 32'h00FF_00F0);
    wr(4'd6, 32'h0000_00C5); rd(4'd6, rv); chk("R2 B ctl", rv, 32'h0000_00C5);
    wr(4'd0, '0); wr(4'd8, '0); wr(4'd6, '0);

    // R11 R10 R12 data-access table on channel B
    for (int i = 0; i < NV; i++) begin
      wr(4'd4, VEC[i].adr);
      wr(4'd5, VEC[i].msk);
      wr(4'd7, VEC[i].dat);
      wr(4'd8, VEC[i].dmk);
      wr(4'd6, W'(VEC[i].ctl));
      wr(4'd9, '0);
      drive(1'b0, 1'b0, 1'b0, 1'b0, VEC[i].wr, VEC[i].sz, VEC[i].ta, VEC[i].td);
      chk("R11 R10 R12 data match", W'(brk_req), W'(VEC[i].exp));
    end
    wr(4'd5, '0); wr(4'd7, '0); wr(4'd8, '0);
    tidy();

    // R3 pre-execution fetch
    wr(4'd0, 32'h100); wr(4'd2, 32'h01);
    fetch(32'h0FC, 1'b1, 1'b0, 1'b0);
    chk("R3 no early break", W'(brk_req), 0);
    fetch(32'h100, 1'b1, 1'b0, 1'b0);
    chk("R3 break", W'(brk_req), 1);
    chk("R3 stop", brk_stop, 32'h100);
    rd(4'd9, rv); chk("R3 status", rv, 1);
    // R2 R13 write 1 keeps, write 0 clears
    wr(4'd9, 32'h3);
    chk("R2 write1 keeps", W'(brk_req), 1);
    fetch(32'h104, 1'b1, 1'b0, 1'b0);
    chk("R13 held", W'(brk_req), 1);
    wr(4'd9, 32'h0);
    chk("R13 cleared", W'(brk_req), 0);

    // R14 second break keeps first stop address
    wr(4'd4, 32'h200); wr(4'd6, 32'h01);
    fetch(32'h100, 1'b1, 1'b0, 1'b0);
    fetch(32'h200, 1'b1, 1'b0, 1'b0);
    rd(4'd9, rv); chk("R14 both flags", rv, 3);
    chk("R14 stop kept", brk_stop, 32'h100);
    rd(4'd10, rv); chk("R14 stop register", rv, 32'h100);
    tidy();

    // R4 odd fetch address never breaks
    wr(4'd0, 32'h101); wr(4'd2, 32'h01);
    fetch(32'h101, 1'b1, 1'b0, 1'b0);
    chk("R4 odd address", W'(brk_req), 0);
    tidy();

    // R5 dropped fetch ignored, also as a branch
    wr(4'd0, 32'h300); wr(4'd2, 32'h01);
    fetch(32'h300, 1'b0, 1'b0, 1'b0);
    chk("R5 dropped fetch", W'(brk_req), 0);
    wr(4'd0, 32'h310);
    fetch(32'h2FC, 1'b1, 1'b0, 1'b0);
    fetch(32'h308, 1'b0, 1'b1, 1'b1);
    fetch(32'h310, 1'b1, 1'b0, 1'b0);
    chk("R5 dropped branch no slot", brk_stop, 32'h310);
    tidy();

    // R6 post-execution on ordinary instruction
    wr(4'd0, 32'h400); wr(4'd2, 32'h41);
    fetch(32'h400, 1'b1, 1'b0, 1'b0);
    chk("R6 not yet", W'(brk_req), 0);
    fetch(32'h404, 1'b1, 1'b0, 1'b0);
    chk("R6 break", W'(brk_req), 1);
    chk("R6 stop", brk_stop, 32'h404);
    tidy();

    // R6 R5 dropped fetch does not complete a post break
    wr(4'd0, 32'hE00); wr(4'd2, 32'h41);
    fetch(32'hE00, 1'b1, 1'b0, 1'b0);
    fetch(32'hE04, 1'b0, 1'b0, 1'b0);
    chk("R5 dropped no post fire", W'(brk_req), 0);
    fetch(32'hE10, 1'b1, 1'b0, 1'b0);
    chk("R6 stop after drop", brk_stop, 32'hE10);
    tidy();

    // R7 pre-execution on delay slot
    wr(4'd0, 32'h502); wr(4'd2, 32'h01);
    fetch(32'h500, 1'b1, 1'b1, 1'b1);
    chk("R7 no break on branch", W'(brk_req), 0);
    fetch(32'h502, 1'b1, 1'b0, 1'b0);
    chk("R7 break", W'(brk_req), 1);
    chk("R7 stop at branch", brk_stop, 32'h500);
    tidy();

    // R8 post-execution on delayed branch
    wr(4'd0, 32'h600); wr(4'd2, 32'h41);
    fetch(32'h600, 1'b1, 1'b1, 1'b1);
    fetch(32'h602, 1'b1, 1'b0, 1'b0);
    chk("R8 held through slot", W'(brk_req), 0);
    fetch(32'h900, 1'b1, 1'b0, 1'b0);
    chk("R8 branch target stop", brk_stop, 32'h900);
    tidy();

    // R8 post-execution on delay slot
    wr(4'd0, 32'h702); wr(4'd2, 32'h41);
    fetch(32'h700, 1'b1, 1'b1, 1'b1);
    fetch(32'h702, 1'b1, 1'b0, 1'b0);
    chk("R8 slot no break yet", W'(brk_req), 0);
    fetch(32'hA00, 1'b1, 1'b0, 1'b0);
    chk("R8 slot target stop", brk_stop, 32'hA00);
    tidy();

    // R9 not-taken branch: following instruction is ordinary
    wr(4'd0, 32'hB02); wr(4'd2, 32'h01);
    fetch(32'hB00, 1'b1, 1'b1, 1'b0);
    fetch(32'hB02, 1'b1, 1'b0, 1'b0);
    chk("R9 pre stop own address", brk_stop, 32'hB02);
    tidy();
    wr(4'd0, 32'hC00); wr(4'd2, 32'h41);
    fetch(32'hC00, 1'b1, 1'b1, 1'b0);
    fetch(32'hC02, 1'b1, 1'b0, 1'b0);
    chk("R9 post fires at next", W'(brk_req), 1);
    chk("R9 post stop", brk_stop, 32'hC02);
    tidy();

    // R12 channel B fetch ignores data compare
    wr(4'd4, 32'hD00); wr(4'd7, 32'hDEAD); wr(4'd6, 32'h81);
    drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd3, 32'hD00, 32'h0);
    chk("R12 fetch ignores data", W'(brk_req), 1);
    rd(4'd9, rv); chk("R12 B flag", rv, 2);
    tidy();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule